// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a system watchdog seen by software as a small set of 32-bit registers. A configuration word carries a 16-bit reload value, an enable, an expiry-action select and a prescale select. Once started, a 16-bit down-counter counts toward zero from the system clock, either directly or through a fixed power-of-two prescaler. Software keeps the system alive by writing a two-word key sequence to a 16-bit service register. Each complete sequence reloads the counter from the configured value.

The configuration can be written only once after reset. A watchdog that has been started therefore cannot be stopped or retuned, and one that was written as disabled cannot be started later. If the counter runs out, the block raises either a reset request or an interrupt, as the select bit chooses. That output stays asserted until the next system reset.

Top module: `wdog_keyed`

## Requirements
- R1: After reset both expiry outputs are low and the count register (byte offset 0x8) reads 0. The configuration register (byte offset 0x4) reads 0xFFFF0000: reload field all ones, every flag bit clear.
- R2: The configuration word packs the reload value in bits 31:16, run enable in bit 2, expiry select in bit 1 and prescale enable in bit 0. All other bits read as zero.
- R3: Only the first configuration write after reset takes effect. Every later write to offset 0x4 leaves the readback and the behaviour unchanged. This holds for a write that tries to clear the enable and for one that tries to set it.
- R4: A configuration write with the enable bit set loads the counter with the written reload value at that clock edge. The count register shows the counter in bits 15:0, and writes to offset 0x8 are ignored.
- R5: With prescaling off, an enabled counter decrements by one on every clock edge while it is nonzero.
- R6: With prescaling on, the counter decrements once per 2**PRE_W clock edges (65536 at the default), counted from the edge that started or reloaded it.
- R7: The counter is reloaded from the configured reload value at the edge that captures a write of 0xAA39 to offset 0xE. This happens only if the previous write to offset 0xE was 0x556C. The key is taken from write-data bits 15:0.
- R8: Any other write to offset 0xE returns the key tracker to idle with no reload. This covers a wrong second word, a repeated first word, or a second word sent alone.
- R9: When an enabled counter reads zero, the next edge raises the reset request if the select bit is 1, or the interrupt if it is 0. The raised output stays high until reset, the counter stays at zero, and later key sequences do nothing.
- R10: A watchdog configured as disabled never counts and never raises either output, whatever is written afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe, one write per cycle |
| bus_addr | input | 4 | Byte offset of the access |
| bus_wdata | input | 32 | Write data; the service key is taken from bits 15:0 |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| wdt_rst_req | output | 1 | Sticky reset request on expiry when select is 1 |
| wdt_irq | output | 1 | Sticky interrupt on expiry when select is 0 |

## Verification
The hardest state to reach from the ports is the key tracker after a broken sequence. A bad word leaves no visible trace, and the only way to tell that the tracker went back to idle is that a later lone 0xAA39 fails to reload the counter.

The bench drives several broken orderings back to back while the counter is running. It then reads the count and confirms that it kept decrementing. After that it sends one correct pair to show the tracker recovers.

Because of the write-once lock, each configuration needs its own reset. The bench therefore runs separate phases for reset-select, interrupt-select with the prescaler, and the disabled case. It shortens the prescaler to 16 clocks so that the prescaled expiry is reachable.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;
  localparam int CNT_W  = 16;
  localparam int KEY_W  = 16;

  // byte offsets seen by software
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_COUNT = 4'h8;
  localparam logic [ADDR_W-1:0] OFS_SVC   = 4'hE;

  // configuration word bit positions
  localparam int CB_PRE    = 0;
  localparam int CB_SEL    = 1;
  localparam int CB_EN     = 2;
  localparam int CB_TO_LSB = 16;
  localparam int CB_FLAGS  = 3;

  localparam logic [KEY_W-1:0] KEY_ARM  = 16'h556C;
  localparam logic [KEY_W-1:0] KEY_FIRE = 16'hAA39;

  typedef enum logic {KS_IDLE = 1'b0, KS_ARMED = 1'b1} key_st_t;

  typedef struct packed {
    logic [CNT_W-1:0] timeout;
    logic             en;
    logic             rsel;
    logic             pre;
  } cfg_t;
endpackage

// File: rtl/wdog_ctrl_reg.sv
module wdog_ctrl_reg
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctrl,
  input  logic [CNT_W-1:0] wr_timeout,
  input  logic             wr_en,
  input  logic             wr_rsel,
  input  logic             wr_pre,
  output cfg_t             cfg,
  output logic             locked,
  output logic             start
);
  cfg_t cfg_q, cfg_d;
  logic lock_q, lock_d;

  always_comb begin
    cfg_d  = cfg_q;
    lock_d = lock_q;
    start  = 1'b0;
    if (wr_ctrl && !lock_q) begin
      cfg_d.timeout = wr_timeout;
      cfg_d.en      = wr_en;
      cfg_d.rsel    = wr_rsel;
      cfg_d.pre     = wr_pre;
      lock_d        = 1'b1;
      start         = wr_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.timeout <= '1;
      cfg_q.en      <= 1'b0;
      cfg_q.rsel    <= 1'b0;
      cfg_q.pre     <= 1'b0;
      lock_q        <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      lock_q <= lock_d;
    end
  end

  assign cfg    = cfg_q;
  assign locked = lock_q;
endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int PRE_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic bypass,
  input  logic clear,
  output logic tick
);
  generate
    if (PRE_W == 0) begin : g_none
      logic unused_pre;
      assign unused_pre = clk ^ rst_n ^ bypass ^ clear;
      assign tick = run;
    end else begin : g_div
      logic [PRE_W-1:0] pc_q, pc_d;
      logic             wrap;

      assign wrap = &pc_q;

      always_comb begin
        pc_d = pc_q;
        if (clear)              pc_d = '0;
        else if (run && !bypass) pc_d = pc_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
      end

      assign tick = run && (bypass || wrap);
    end
  endgenerate
endmodule

// File: rtl/wdog_key_fsm.sv
module wdog_key_fsm
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_svc,
  input  logic [KEY_W-1:0] key,
  output logic             fire
);
  key_st_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    fire = 1'b0;
    if (wr_svc) begin
      unique case (st_q)
        KS_IDLE:  st_d = (key == KEY_ARM) ? KS_ARMED : KS_IDLE;
        KS_ARMED: begin
          fire = (key == KEY_FIRE);
          st_d = KS_IDLE;
        end
        default:  st_d = KS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= KS_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/wdog_down_counter.sv
module wdog_down_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  output logic [W-1:0] cnt,
  output logic         expired
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         exp_q, exp_d;
  logic         at_zero;

  assign at_zero = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load)                 cnt_d = load_val;
    else if (tick && !at_zero) cnt_d = cnt_q - 1'b1;
    exp_d = exp_q | (run & at_zero);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      exp_q <= exp_d;
    end
  end

  assign cnt     = cnt_q;
  assign expired = exp_q;
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
  import wdog_pkg::*;
#(
  parameter int PRE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wdt_rst_req,
  output logic              wdt_irq
);
  localparam int PAD_W = DATA_W - CNT_W - CB_FLAGS;

  logic [1:0]        rs_q;
  logic              rst_sync_n;
  cfg_t              cfg;
  logic              cfg_locked;
  logic              start;
  logic              svc_fire;
  logic              reload_ok;
  logic              load;
  logic [CNT_W-1:0]  load_val;
  logic              tick;
  logic [CNT_W-1:0]  count_q;
  logic              expired;
  logic [DATA_W-1:0] ctrl_word;
  logic              wr_ctrl, wr_svc;
  logic              unused_wdata;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  assign wr_ctrl = bus_wr && (bus_addr == OFS_CTRL);
  assign wr_svc  = bus_wr && (bus_addr == OFS_SVC);
  assign unused_wdata = ^bus_wdata[CB_TO_LSB-1:CB_FLAGS];

  wdog_ctrl_reg u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_ctrl    (wr_ctrl),
    .wr_timeout (bus_wdata[CB_TO_LSB +: CNT_W]),
    .wr_en      (bus_wdata[CB_EN]),
    .wr_rsel    (bus_wdata[CB_SEL]),
    .wr_pre     (bus_wdata[CB_PRE]),
    .cfg        (cfg),
    .locked     (cfg_locked),
    .start      (start)
  );

  wdog_key_fsm u_keys (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_svc (wr_svc),
    .key    (bus_wdata[KEY_W-1:0]),
    .fire   (svc_fire)
  );

  assign reload_ok = svc_fire && cfg.en && !expired && (count_q != '0);
  assign load      = start || reload_ok;
  assign load_val  = start ? bus_wdata[CB_TO_LSB +: CNT_W] : cfg.timeout;

  wdog_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .run    (cfg.en),
    .bypass (!cfg.pre),
    .clear  (load),
    .tick   (tick)
  );

  wdog_down_counter #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .run      (cfg.en),
    .load     (load),
    .load_val (load_val),
    .tick     (tick),
    .cnt      (count_q),
    .expired  (expired)
  );

  assign ctrl_word = {cfg.timeout, {PAD_W{1'b0}}, cfg.en, cfg.rsel, cfg.pre};

  always_comb begin
    unique case (bus_addr)
      OFS_CTRL:  bus_rdata = ctrl_word;
      OFS_COUNT: bus_rdata = {{(DATA_W-CNT_W){1'b0}}, count_q};
      default:   bus_rdata = '0;
    endcase
  end

  assign wdt_rst_req = expired &&  cfg.rsel;
  assign wdt_irq     = expired && !cfg.rsel;
endmodule

// File: rtl/wdog_keyed_chk.sv
module wdog_keyed_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] ctrl_word,
  input logic        locked,
  input logic        en,
  input logic        pre,
  input logic [15:0] cnt,
  input logic        load,
  input logic        rst_req,
  input logic        irq
);
  // R3: configuration frozen once locked
  p_frozen_cfg_r3: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(ctrl_word));

  // R5: unprescaled step of exactly one
  p_step_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !pre && !load && cnt != 16'd0) |=> (cnt == $past(cnt) - 16'd1));

  // R9: outputs are sticky
  p_sticky_rst_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req);
  p_sticky_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> irq);

  // R9: never both, counter parked at zero once expired
  p_one_action_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_req && irq));
  p_zero_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req || irq) |-> (cnt == 16'd0));

  // R10: a disabled watchdog stays idle
  p_idle_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !en) |-> (cnt == 16'd0 && !rst_req && !irq));
endmodule

bind wdog_keyed wdog_keyed_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .ctrl_word (ctrl_word),
  .locked    (cfg_locked),
  .en        (cfg.en),
  .pre       (cfg.pre),
  .cnt       (count_q),
  .load      (load),
  .rst_req   (wdt_rst_req),
  .irq       (wdt_irq)
);

// File: tb/wdog_keyed_tb_top.sv
`timescale 1ns/1ps
module wdog_keyed_tb_top;
  localparam int PRE_W  = 4;
  localparam int PSTEPS = 1 << PRE_W;

  logic        clk;
  logic        rst_n;
  logic        wr;
  logic [3:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        rst_req, irq;

  int errors = 0;
  int checks = 0;
  int cyc    = 0;
  bit done   = 0;

  wdog_keyed #(.PRE_W(PRE_W)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (wr),
    .bus_addr    (addr),
    .bus_wdata   (wdata),
    .bus_rdata   (rdata),
    .wdt_rst_req (rst_req),
    .wdt_irq     (irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // behavioural reference model
  bit m_lock, m_en, m_rsel, m_pre, m_exp, m_armed;
  int m_to, m_cnt, m_pc;
  bit t_tick, t_start, t_rel;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lock = 0; m_en = 0; m_rsel = 0; m_pre = 0; m_exp = 0; m_armed = 0;
      m_to = 16'hFFFF; m_cnt = 0; m_pc = 0;
    end else begin
      t_tick  = m_en && (!m_pre || m_pc == PSTEPS - 1);
      t_start = wr && addr == 4'h4 && !m_lock && wdata[2];
      t_rel   = wr && addr == 4'hE && m_armed && wdata[15:0] == 16'hAA39
                && m_en && !m_exp && m_cnt != 0;
      if (m_en && m_cnt == 0) m_exp = 1;
      if (t_start || t_rel) m_pc = 0;
      else if (m_en && m_pre) m_pc = (m_pc + 1) % PSTEPS;
      if (t_start)                   m_cnt = int'(wdata[31:16]);
      else if (t_rel)                m_cnt = m_to;
      else if (t_tick && m_cnt > 0)  m_cnt = m_cnt - 1;
      if (wr && addr == 4'hE) m_armed = !m_armed && wdata[15:0] == 16'h556C;
      if (wr && addr == 4'h4 && !m_lock) begin
        m_lock = 1;
        m_to   = int'(wdata[31:16]);
        m_en   = wdata[2];
        m_rsel = wdata[1];
        m_pre  = wdata[0];
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #3;
    if (rst_n && !done) begin
      check("R9 rst_req vs model", {31'b0, rst_req}, {31'b0, m_exp && m_rsel});
      check("R9 irq vs model",     {31'b0, irq},     {31'b0, m_exp && !m_rsel});
      if (addr == 4'h8)
        check("R4 count vs model", rdata, m_cnt);
    end
  end

  task automatic finish_run();
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cyc);
      finish_run();
    end
  end

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; addr = 4'h8; wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    addr = a;
    #1 v = rdata;
    addr = 4'h8;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr = 1'b0; addr = 4'h8; wdata = '0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(4);
  endtask

  task automatic svc(input logic [15:0] k);
    bus_wr(4'hE, {16'h0, k});
  endtask

  logic [31:0] v0, v1;

  initial begin
    rst_n = 1'b0; wr = 1'b0; addr = 4'h8; wdata = '0;

    // phase A: reset state, reset-select, no prescale
    do_reset();
    rd(4'h4, v0); check("R1 ctrl reset value", v0, 32'hFFFF0000);
    rd(4'h8, v0); check("R1 count reset value", v0, 32'h0);
    check("R1 outputs low", {30'b0, rst_req, irq}, 32'h0);

    bus_wr(4'h4, 32'h0014_0006);
    rd(4'h8, v0); check("R4 load on enable", v0, 32'd20);
    rd(4'h4, v0); check("R2 field readback", v0, 32'h0014_0006);
    bus_wr(4'h4, 32'h0005_0000);
    rd(4'h4, v0); check("R3 second write ignored", v0, 32'h0014_0006);

    rd(4'h8, v0);
    bus_wr(4'h8, 32'h0000_0005);
    rd(4'h8, v1); check("R4 count write ignored", v1, v0 - 1);

    rd(4'h8, v0);
    wait_n(5);
    rd(4'h8, v1); check("R5 one step per clock", v1, v0 - 5);

    svc(16'h556C); svc(16'hAA39);
    rd(4'h8, v0); check("R7 service reload", v0, 32'd20);

    svc(16'h556C); svc(16'h1234); svc(16'hAA39);
    rd(4'h8, v0); check("R8 wrong second key", v0, 32'd17);
    svc(16'h556C); svc(16'h556C); svc(16'hAA39);
    rd(4'h8, v0); check("R8 repeated first key", v0, 32'd14);
    svc(16'hAA39);
    rd(4'h8, v0); check("R8 lone second key", v0, 32'd13);
    svc(16'h556C); svc(16'hAA39);
    rd(4'h8, v0); check("R7 tracker recovers", v0, 32'd20);

    wait_n(25);
    check("R9 reset request raised", {30'b0, rst_req, irq}, 32'h2);
    rd(4'h8, v0); check("R9 count parked", v0, 32'h0);
    svc(16'h556C); svc(16'hAA39);
    wait_n(5);
    rd(4'h8, v0); check("R9 keys after expiry", v0, 32'h0);
    check("R9 still asserted", {30'b0, rst_req, irq}, 32'h2);

    // phase B: interrupt-select with prescale
    do_reset();
    check("R1 outputs low again", {30'b0, rst_req, irq}, 32'h0);
    bus_wr(4'h4, 32'h0003_0005);
    rd(4'h8, v0); check("R6 start value", v0, 32'd3);
    wait_n(PSTEPS - 1);
    rd(4'h8, v0); check("R6 no step before period", v0, 32'd3);
    wait_n(1);
    rd(4'h8, v0); check("R6 step at period", v0, 32'd2);
    wait_n(3 * PSTEPS);
    check("R9 interrupt raised", {30'b0, rst_req, irq}, 32'h1);
    wait_n(10);
    check("R9 interrupt sticky", {30'b0, rst_req, irq}, 32'h1);

    // phase C: written disabled
    do_reset();
    bus_wr(4'h4, 32'h0010_0002);
    bus_wr(4'h4, 32'h0010_0004);
    rd(4'h4, v0); check("R3 cannot enable later", v0, 32'h0010_0002);
    svc(16'h556C); svc(16'hAA39);
    wait_n(40);
    rd(4'h8, v0); check("R10 counter idle", v0, 32'h0);
    check("R10 outputs low", {30'b0, rst_req, irq}, 32'h0);

    wait_n(2);
    finish_run();
  end
endmodule